// File: doc/BRIEF.md
# Fetch Address Selector and Next-Address Predictor

This block chooses the address an in-order five-stage pipeline fetches from on every cycle, and guesses where the following instruction will be. The guess comes only from the instruction now in fetch. A plain instruction continues at its sequential successor. A call or any jump continues at its encoded target, so every conditional jump is assumed taken. The guess is stored in a predicted-address register. That register advances each cycle unless the fetch hold input is raised.

Two late corrections can override the stored guess. A conditional jump that reaches the memory stage and turns out not taken sends fetch back to the sequential address that the jump carried along. A return instruction is never guessed. Instead, fetch waits until the return reaches write-back, then uses the address that the return loaded from memory. The block also flags whenever a return sits in decode, execute or memory, so that the pipeline controller can hold fetch during that window. Instruction memory, decoding and hazard control stay outside the block.

Top module: `fetch_npc`

## Requirements
- R1: A synchronous active-low reset clears the predicted-address register to address 0, and reset takes effect even while fetch_hold is high.
- R2: For any fetch opcode other than jump (4'h7) or call (4'h8), returns included, pred_next equals f_seq_addr.
- R3: For a call (f_op = 4'h8), pred_next equals f_imm.
- R4: For every jump (f_op = 4'h7), pred_next equals f_imm whatever the jump's condition, because all jumps are predicted taken.
- R5: When m_op is jump (4'h7) and m_taken is 0, fetch_pc equals m_seq_addr.
- R6: When w_op is return (4'h9) and R5 does not apply, fetch_pc equals w_load_data.
- R7: When both R5 and R6 conditions hold, the mispredict address from R5 wins.
- R8: When neither correction applies, fetch_pc equals pred_pc. A jump in the memory stage with m_taken = 1 causes no correction.
- R9: On a clock edge with rst_n high and fetch_hold low, pred_pc takes the value pred_next had before the edge. With fetch_hold high, pred_pc keeps its value.
- R10: ret_wait is 1 exactly when any of d_op, e_op or m_op is return (4'h9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_hold | input | 1 | Freezes the predicted-address register |
| f_op | input | 4 | Opcode of the instruction in fetch |
| f_seq_addr | input | ADDR_W | Sequential successor address of the fetched instruction |
| f_imm | input | ADDR_W | Encoded constant (target) of the fetched instruction |
| d_op | input | 4 | Opcode in decode |
| e_op | input | 4 | Opcode in execute |
| m_op | input | 4 | Opcode in memory stage |
| m_taken | input | 1 | Resolved condition of the jump in memory stage |
| m_seq_addr | input | ADDR_W | Sequential address carried by the memory-stage instruction |
| w_op | input | 4 | Opcode in write-back |
| w_load_data | input | ADDR_W | Value loaded by the write-back instruction |
| fetch_pc | output | ADDR_W | Address to fetch this cycle |
| pred_next | output | ADDR_W | Guessed address of the next instruction |
| pred_pc | output | ADDR_W | Predicted-address register |
| ret_wait | output | 1 | A return is in decode, execute or memory |

## Verification
The embedded properties check on every cycle that the fetch address source follows the fixed priority (mispredict, then return, then register). They also check that calls and jumps guess their target, that the register advances or holds as fetch_hold says, that reset clears it, and that the return-pending flag tracks the three stage opcodes. Only the bench scenarios show some of the end-to-end behaviour. These are: a taken jump in the memory stage leaving the stored guess untouched, reset winning over hold, and a run of held cycles followed by release that picks up the guess of the instruction then in fetch.

// File: rtl/npc_pkg.sv
// Package: shared opcode type and the opcode values this block decodes.
// Assumes a 4-bit opcode field supplied already decoded by earlier logic.
package npc_pkg;
    typedef logic [3:0] opcode_t;
    localparam opcode_t OP_JUMP = 4'h7;
    localparam opcode_t OP_CALL = 4'h8;
    localparam opcode_t OP_RET  = 4'h9;
endpackage

// File: rtl/npc_guess.sv
// Module: computes the guessed next address from the instruction in fetch.
// Assumes all jumps are taken; returns are not guessed (sequential used).
module npc_guess
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  opcode_t           op,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] imm,
    output logic [ADDR_W-1:0] guess
);
    logic use_target;

    // Decide whether the instruction redirects to its encoded constant.
    always_comb begin
        use_target = (op == OP_JUMP) || (op == OP_CALL);
    end

    // Pick target or sequential successor.
    always_comb begin
        guess = use_target ? imm : seq_addr;
    end
endmodule

// File: rtl/npc_recover_mux.sv
// Module: chooses the fetch address with fixed priority:
// mispredicted jump, then write-back return, then stored guess.
// Assumes stage opcodes are valid every cycle (bubbles carry a non-control code).
module npc_recover_mux
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  opcode_t           m_op,
    input  logic              m_taken,
    input  logic [ADDR_W-1:0] m_seq_addr,
    input  opcode_t           w_op,
    input  logic [ADDR_W-1:0] w_load_data,
    input  logic [ADDR_W-1:0] stored_pc,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              mispredict,
    output logic              ret_resolve
);
    // Flag the two correction events.
    always_comb begin
        mispredict  = (m_op == OP_JUMP) && !m_taken;
        ret_resolve = (w_op == OP_RET);
    end

    // Priority select of the fetch address.
    always_comb begin
        if (mispredict)       fetch_pc = m_seq_addr;
        else if (ret_resolve) fetch_pc = w_load_data;
        else                  fetch_pc = stored_pc;
    end
endmodule

// File: rtl/npc_pred_reg.sv
// Module: predicted-address register with hold and synchronous active-low reset.
// Assumes reset overrides hold.
module npc_pred_reg #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Load the guess unless held; reset to RESET_PC.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RESET_PC;
        else if (!hold) q <= d;
    end
endmodule

// File: rtl/npc_ret_watch.sv
// Module: raises a flag while a return occupies any watched stage.
// Assumes watched stage opcodes arrive packed in one vector.
module npc_ret_watch
    import npc_pkg::*;
#(
    parameter int N_STAGES = 3
) (
    input  opcode_t [N_STAGES-1:0] ops,
    output logic                   ret_seen
);
    logic [N_STAGES-1:0] hit;

    // One comparator per watched stage.
    for (genvar i = 0; i < N_STAGES; i++) begin : g_cmp
        assign hit[i] = (ops[i] == OP_RET);
    end

    // Any stage holding a return.
    always_comb begin
        ret_seen = |hit;
    end
endmodule

// File: rtl/fetch_npc.sv
// Module: fetch address selector and next-address predictor (top).
// Assumes the hazard controller drives fetch_hold (e.g. from ret_wait).
module fetch_npc
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_hold,
    input  logic [3:0]        f_op,
    input  logic [ADDR_W-1:0] f_seq_addr,
    input  logic [ADDR_W-1:0] f_imm,
    input  logic [3:0]        d_op,
    input  logic [3:0]        e_op,
    input  logic [3:0]        m_op,
    input  logic              m_taken,
    input  logic [ADDR_W-1:0] m_seq_addr,
    input  logic [3:0]        w_op,
    input  logic [ADDR_W-1:0] w_load_data,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_next,
    output logic [ADDR_W-1:0] pred_pc,
    output logic              ret_wait
);
    localparam int N_WATCH = 3;
    localparam logic [ADDR_W-1:0] RESET_PC = '0;

    logic mispredict;
    logic ret_resolve;
    opcode_t [N_WATCH-1:0] watch_ops;

    // Gather the decode, execute and memory opcodes for the return watch.
    always_comb begin
        watch_ops = {d_op, e_op, m_op};
    end

    npc_guess #(.ADDR_W(ADDR_W)) u_guess (
        .op(f_op), .seq_addr(f_seq_addr), .imm(f_imm), .guess(pred_next)
    );

    npc_pred_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_preg (
        .clk(clk), .rst_n(rst_n), .hold(fetch_hold), .d(pred_next), .q(pred_pc)
    );

    npc_recover_mux #(.ADDR_W(ADDR_W)) u_sel (
        .m_op(m_op), .m_taken(m_taken), .m_seq_addr(m_seq_addr),
        .w_op(w_op), .w_load_data(w_load_data), .stored_pc(pred_pc),
        .fetch_pc(fetch_pc), .mispredict(mispredict), .ret_resolve(ret_resolve)
    );

    npc_ret_watch #(.N_STAGES(N_WATCH)) u_watch (
        .ops(watch_ops), .ret_seen(ret_wait)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> pred_pc == RESET_PC); // R1
    AST_NONCTRL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op != OP_JUMP && f_op != OP_CALL) |-> pred_next == f_seq_addr); // R2
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op == OP_CALL) |-> pred_next == f_imm); // R3
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op == OP_JUMP) |-> pred_next == f_imm); // R4
    AST_MISPRED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_op == OP_JUMP && !m_taken) |-> fetch_pc == m_seq_addr); // R5 R7
    AST_RET_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!(m_op == OP_JUMP && !m_taken) && w_op == OP_RET) |-> fetch_pc == w_load_data); // R6
    AST_STORED_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispredict && !ret_resolve) |-> fetch_pc == pred_pc); // R8
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_hold |=> pred_pc == $past(pred_next)); // R9
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |=> $stable(pred_pc)); // R9
    AST_RET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ret_wait == (d_op == OP_RET || e_op == OP_RET || m_op == OP_RET)); // R10
endmodule

// File: tb/fetch_npc_bench.sv
module fetch_npc_bench;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_hold = 1'b0;
    logic [3:0] f_op = 4'h0, d_op = 4'h0, e_op = 4'h0, m_op = 4'h0, w_op = 4'h0;
    logic m_taken = 1'b1;
    logic [AW-1:0] f_seq_addr = '0, f_imm = '0, m_seq_addr = '0, w_load_data = '0;
    logic [AW-1:0] fetch_pc, pred_next, pred_pc;
    logic ret_wait;

    always #2 clk = ~clk; // 250 MHz

    fetch_npc #(.ADDR_W(AW)) u_fetch_npc (
        .clk(clk), .rst_n(rst_n), .fetch_hold(fetch_hold),
        .f_op(f_op), .f_seq_addr(f_seq_addr), .f_imm(f_imm),
        .d_op(d_op), .e_op(e_op), .m_op(m_op), .m_taken(m_taken),
        .m_seq_addr(m_seq_addr), .w_op(w_op), .w_load_data(w_load_data),
        .fetch_pc(fetch_pc), .pred_next(pred_next), .pred_pc(pred_pc),
        .ret_wait(ret_wait)
    );

    typedef struct {
        int            req;
        logic [AW-1:0] fpc;
        logic [AW-1:0] pnext;
        logic [AW-1:0] preg;
        logic          rw;
    } exp_t;

    exp_t sb[$];
    logic [AW-1:0] model_preg = '0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic cmp(input int req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one vector at the falling edge and pushes its expectation.
    task automatic apply(input int req, input logic [3:0] fo, input logic [AW-1:0] seq,
                         input logic [AW-1:0] imm, input logic [3:0] dop, input logic [3:0] eop,
                         input logic [3:0] mop, input logic mtk, input logic [AW-1:0] mseq,
                         input logic [3:0] wop, input logic [AW-1:0] wdat, input logic hold);
        exp_t e;
        @(negedge clk);
        f_op = fo; f_seq_addr = seq; f_imm = imm; d_op = dop; e_op = eop;
        m_op = mop; m_taken = mtk; m_seq_addr = mseq; w_op = wop; w_load_data = wdat;
        fetch_hold = hold;
        e.req   = req;
        e.preg  = model_preg;
        e.pnext = (fo == 4'h7 || fo == 4'h8) ? imm : seq;
        if (mop == 4'h7 && !mtk) e.fpc = mseq;
        else if (wop == 4'h9)    e.fpc = wdat;
        else                     e.fpc = model_preg;
        e.rw = (dop == 4'h9) || (eop == 4'h9) || (mop == 4'h9);
        sb.push_back(e);
        if (!hold) model_preg = e.pnext;
    endtask

    // Monitor: pops expectations shortly after each falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.req, "fetch_pc", fetch_pc, e.fpc);
                cmp(e.req, "pred_next", pred_next, e.pnext);
                cmp(e.req, "pred_pc", pred_pc, e.preg);
                cmp(10, "ret_wait", {31'b0, ret_wait}, {31'b0, e.rw});
            end
        end
    end

    initial begin
        // Watchdog: a hung run counts as a failure.
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R0 watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_preg = '0;
        // R1 reset state: stored guess is 0, fetch uses it
        apply(1, 4'h0, 32'h0000_0002, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R2 plain instruction continues sequentially
        apply(2, 4'h3, 32'h0000_0014, 32'h0000_0BAD, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R3 call goes to its target
        apply(3, 4'h8, 32'h0000_0019, 32'h0000_0200, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R4 conditional jump predicted taken
        apply(4, 4'h7, 32'h0000_0205, 32'h0000_0300, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R8 taken jump in memory stage: no correction
        apply(8, 4'h1, 32'h0000_0301, 32'h0, 4'h0, 4'h0, 4'h7, 1, 32'h0000_0777, 4'h0, 32'h0, 0);
        // R5 not-taken jump: fall back to carried sequential address
        apply(5, 4'h2, 32'h0000_0303, 32'h0, 4'h0, 4'h0, 4'h7, 0, 32'h0000_0205, 4'h0, 32'h0, 0);
        // R2 return in fetch: sequential guess, not predicted
        apply(2, 4'h9, 32'h0000_0207, 32'h0000_0999, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R10 R9 return in decode: flag raised, register held
        apply(10, 4'h1, 32'h0000_0208, 32'h0, 4'h9, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 1);
        // R10 R9 return in execute, held
        apply(10, 4'h1, 32'h0000_0208, 32'h0, 4'h0, 4'h9, 4'h0, 1, 32'h0, 4'h0, 32'h0, 1);
        // R10 R9 return in memory, held
        apply(9, 4'h1, 32'h0000_0208, 32'h0, 4'h0, 4'h0, 4'h9, 1, 32'h0, 4'h0, 32'h0, 1);
        // R6 return in write-back: loaded address used
        apply(6, 4'h3, 32'h0000_0401, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h9, 32'h0000_001A, 0);
        // R7 both corrections at once: mispredict wins
        apply(7, 4'h0, 32'h0000_0500, 32'h0, 4'h0, 4'h0, 4'h7, 0, 32'h0000_0123, 4'h9, 32'h0000_0456, 0);
        // R4 unconditional jump to target
        apply(4, 4'h7, 32'h0000_0505, 32'hFFFF_FFF0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R9 stored guess visible, then held
        apply(9, 4'h0, 32'h0000_0010, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 1);
        apply(9, 4'h0, 32'h0000_0020, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        apply(9, 4'h0, 32'h0000_0030, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        // R1 reset wins over hold
        @(negedge clk);
        rst_n = 1'b0; fetch_hold = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        model_preg = '0;
        apply(1, 4'h0, 32'h0000_0044, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 1);
        apply(1, 4'h0, 32'h0000_0048, 32'h0, 4'h0, 4'h0, 4'h0, 1, 32'h0, 4'h0, 32'h0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule